// File: doc/BRIEF.md
# Event Counter Monitor

This block is a memory-mapped performance monitor for a coherence protocol adapter. It holds eight 64-bit counters. Each counter is tied to one line of a 256-wide event vector through an 8-bit event code. On every clock cycle in which that line is high, the counter advances by one, as long as counting is allowed for it. Software controls the block through a 32-bit register port. A 64-bit path lets software preload each counter and read it back. When a counter rolls over, it raises a sticky pending flag. Any pending flag that is not masked drives a single registered interrupt line.

Counting for counter n needs two conditions: bit 0 of the global control word, and bit n of the counter enable word. Event codes are packed four to a 32-bit select word. Two event lines have a fixed meaning: line 0x40 marks received requests and line 0x5C marks transmitted requests. Line 0x78 is a free-running cycle strobe.

Top module: `evmon_top`

## Requirements
- R1: After reset the global control, counter enable, status and select words read zero, the mask word reads 0xFF, the interrupt is low, every counter reads zero, and offset 0xF0 returns the VERSION parameter.
- R2: A 64-bit write with address 0x100 + 8·n loads counter n, and a 64-bit read at that address returns its value.
- R3: Counter n advances only in cycles where bit 0 of the word at 0x00 and bit n of the word at 0x04 are both set; if either is clear, its value holds.
- R4: Counter n takes its event code from the select word at 0x80 (n < 4) or 0x84 (n ≥ 4), bits 8·(n mod 4)+7 down to 8·(n mod 4). It advances by one per cycle in which ev_i[code] is high.
- R5: When a counter advances from all-ones, it becomes zero and sets status bit n, readable at 0x78, on the same clock edge.
- R6: Writing 0x7C clears each status bit whose data bit is 1 and leaves bits written as 0 unchanged. A rollover in the same cycle as a clear of that bit leaves the bit set.
- R7: irq_o is one register stage behind the OR over n of (status bit n AND NOT mask bit n). The mask word sits at 0x70, and a 1 in it suppresses that counter.
- R8: A 64-bit write to a counter in the same cycle as an event for it stores the written value, with no increment.
- R9: The 32-bit path returns zero at unmapped offsets, at 0x7C and inside the counter window. The 64-bit path returns zero for misaligned or out-of-range addresses. Writes to 0xF0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 9 | Byte offset shared by both access paths |
| reg_wr | input | 1 | 32-bit register write strobe |
| reg_wdata | input | 32 | 32-bit write data |
| reg_rdata | output | 32 | 32-bit read data for reg_addr (combinational) |
| cnt_wr | input | 1 | 64-bit counter write strobe |
| cnt_wdata | input | 64 | Counter preload value |
| cnt_rdata | output | 64 | Counter value at reg_addr (combinational) |
| ev_i | input | 256 | Event pulses indexed by event code |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bound checker covers several properties on every cycle. Counters hold while the global enable is off and no preload is written. A status bit rises only together with a counter reading zero. Every rollover seen from all-ones sets its status bit, including when it collides with a clear. The interrupt tracks the masked status one cycle later. The directed scenarios are needed for the rest: select-word lane packing, per-counter gating, preload priority over a simultaneous event, write-one-to-clear with zero bits, and the zero reads of unmapped and misaligned addresses. Those scenarios depend on which address and code values software uses.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
    // Register block offsets (bytes)
    localparam int OFF_CTRL = 32'h000;
    localparam int OFF_EVEN = 32'h004;
    localparam int OFF_MASK = 32'h070;
    localparam int OFF_STAT = 32'h078;
    localparam int OFF_CLR  = 32'h07C;
    localparam int OFF_SEL  = 32'h080;
    localparam int OFF_VER  = 32'h0F0;
    localparam int OFF_CNT  = 32'h100;
    localparam int CNT_STRIDE_LG = 3;
    localparam int BUS_W    = 32;
endpackage

// File: rtl/evmon_counter.sv
module evmon_counter #(
    parameter int CNT_W  = 64,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic [CODE_W-1:0]        code,
    input  logic [(1<<CODE_W)-1:0]   ev_vec,
    input  logic                     wr,
    input  logic [CNT_W-1:0]         wdata,
    output logic [CNT_W-1:0]         value,
    output logic                     wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic hit;

    always_comb begin
        s_d  = s_q;
        wrap = 1'b0;
        hit  = run & ev_vec[code];
        if (wr) begin
            s_d.val = wdata;
        end else if (hit) begin
            s_d.val = s_q.val + CNT_W'(1);
            wrap    = &s_q.val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign value = s_q.val;
endmodule

// File: rtl/evmon_regs.sv
module evmon_regs
    import evmon_pkg::*;
#(
    parameter int          NUM_CNT = 8,
    parameter int          CODE_W  = 8,
    parameter int          ADDR_W  = 9,
    parameter logic [31:0] VERSION = 32'h0001_0200
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr,
    input  logic [BUS_W-1:0]           wdata,
    input  logic [NUM_CNT-1:0]         wrap,
    output logic [BUS_W-1:0]           rdata,
    output logic                       glob_en,
    output logic [NUM_CNT-1:0]         cnt_en,
    output logic [NUM_CNT*CODE_W-1:0]  codes,
    output logic [NUM_CNT-1:0]         status,
    output logic [NUM_CNT-1:0]         mask,
    output logic                       irq
);
    localparam int LANES   = BUS_W / CODE_W;
    localparam int NUM_SEL = (NUM_CNT + LANES - 1) / LANES;

    typedef struct packed {
        logic                           gen;
        logic [NUM_CNT-1:0]             en;
        logic [NUM_CNT-1:0]             msk;
        logic [NUM_CNT-1:0]             st;
        logic [NUM_SEL-1:0][BUS_W-1:0]  sel;
        logic                           irq;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic [NUM_CNT-1:0] clr;

    // Next-state computation
    always_comb begin
        s_d = s_q;
        clr = '0;
        if (wr) begin
            if (addr == ADDR_W'(OFF_CTRL)) s_d.gen = wdata[0];
            if (addr == ADDR_W'(OFF_EVEN)) s_d.en  = wdata[NUM_CNT-1:0];
            if (addr == ADDR_W'(OFF_MASK)) s_d.msk = wdata[NUM_CNT-1:0];
            if (addr == ADDR_W'(OFF_CLR))  clr     = wdata[NUM_CNT-1:0];
            for (int i = 0; i < NUM_SEL; i++) begin
                if (addr == ADDR_W'(OFF_SEL + 4*i)) s_d.sel[i] = wdata;
            end
        end
        // a rollover wins over a clear of the same bit
        s_d.st  = (s_q.st & ~clr) | wrap;
        s_d.irq = |(s_q.st & ~s_q.msk);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.msk <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_CTRL)) rdata = BUS_W'(s_q.gen);
        if (addr == ADDR_W'(OFF_EVEN)) rdata = BUS_W'(s_q.en);
        if (addr == ADDR_W'(OFF_MASK)) rdata = BUS_W'(s_q.msk);
        if (addr == ADDR_W'(OFF_STAT)) rdata = BUS_W'(s_q.st);
        if (addr == ADDR_W'(OFF_VER))  rdata = VERSION;
        for (int i = 0; i < NUM_SEL; i++) begin
            if (addr == ADDR_W'(OFF_SEL + 4*i)) rdata = s_q.sel[i];
        end
    end

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_code
        assign codes[n*CODE_W +: CODE_W] =
            s_q.sel[n/LANES][(n%LANES)*CODE_W +: CODE_W];
    end

    assign glob_en = s_q.gen;
    assign cnt_en  = s_q.en;
    assign status  = s_q.st;
    assign mask    = s_q.msk;
    assign irq     = s_q.irq;
endmodule

// File: rtl/evmon_top.sv
module evmon_top
    import evmon_pkg::*;
#(
    parameter int          NUM_CNT = 8,
    parameter int          CNT_W   = 64,
    parameter int          CODE_W  = 8,
    parameter int          ADDR_W  = 9,
    parameter logic [31:0] VERSION = 32'h0001_0200
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_wr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    input  logic                     cnt_wr,
    input  logic [CNT_W-1:0]         cnt_wdata,
    output logic [CNT_W-1:0]         cnt_rdata,
    input  logic [(1<<CODE_W)-1:0]   ev_i,
    output logic                     irq_o
);
    localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

    logic                              glob_en;
    logic [NUM_CNT-1:0]                cnt_en;
    logic [NUM_CNT*CODE_W-1:0]         codes;
    logic [NUM_CNT-1:0]                status;
    logic [NUM_CNT-1:0]                mask;
    logic [NUM_CNT-1:0]                wrap;
    logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_flat;
    logic [ADDR_W-1:0]                 rel;
    logic                              win_hit;
    logic [IDX_W-1:0]                  idx;

    evmon_regs #(
        .NUM_CNT (NUM_CNT),
        .CODE_W  (CODE_W),
        .ADDR_W  (ADDR_W),
        .VERSION (VERSION)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .wrap    (wrap),
        .rdata   (reg_rdata),
        .glob_en (glob_en),
        .cnt_en  (cnt_en),
        .codes   (codes),
        .status  (status),
        .mask    (mask),
        .irq     (irq_o)
    );

    // Counter window decode: aligned 8-byte slots from OFF_CNT
    always_comb begin
        rel     = reg_addr - ADDR_W'(OFF_CNT);
        win_hit = (reg_addr >= ADDR_W'(OFF_CNT)) &&
                  (rel[CNT_STRIDE_LG-1:0] == '0) &&
                  ((rel >> CNT_STRIDE_LG) < ADDR_W'(NUM_CNT));
        idx     = rel[CNT_STRIDE_LG +: IDX_W];
        cnt_rdata = '0;
        for (int n = 0; n < NUM_CNT; n++) begin
            if (win_hit && idx == IDX_W'(n)) cnt_rdata = cnt_flat[n];
        end
    end

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        evmon_counter #(
            .CNT_W  (CNT_W),
            .CODE_W (CODE_W)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (glob_en & cnt_en[n]),
            .code   (codes[n*CODE_W +: CODE_W]),
            .ev_vec (ev_i),
            .wr     (cnt_wr && win_hit && idx == IDX_W'(n)),
            .wdata  (cnt_wdata),
            .value  (cnt_flat[n]),
            .wrap   (wrap[n])
        );
    end
endmodule

// File: rtl/evmon_chk.sv
module evmon_chk #(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 64
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          glob_en,
    input logic                          cnt_wr,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_flat,
    input logic [NUM_CNT-1:0]            status,
    input logic [NUM_CNT-1:0]            mask,
    input logic                          irq_o
);
    // R3: with counting off and no preload, every counter holds
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !cnt_wr) |=> $stable(cnt_flat));

    // R7: interrupt is the masked status, one register later
    assert_irq_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(status & ~mask))));

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_chk
        // R5: a pending bit appears only alongside a counter at zero
        assert_flag_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(status[n]) && status[n]) |-> (cnt_flat[n] == '0));

        // R6: a rollover sets its bit even against a same-cycle clear
        assert_wrap_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(cnt_flat[n]) == {CNT_W{1'b1}}) && (cnt_flat[n] == '0) && !$past(cnt_wr))
            |-> status[n]);
    end
endmodule

bind evmon_top evmon_chk #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W)
) u_evmon_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .glob_en  (glob_en),
    .cnt_wr   (cnt_wr),
    .cnt_flat (cnt_flat),
    .status   (status),
    .mask     (mask),
    .irq_o    (irq_o)
);

// File: tb/test_evmon_top.sv
module test_evmon_top;
    localparam logic [31:0] VER   = 32'h0001_0200;
    localparam int A_CTRL = 'h000, A_EVEN = 'h004, A_MASK = 'h070, A_STAT = 'h078;
    localparam int A_CLR  = 'h07C, A_SEL0 = 'h080, A_SEL1 = 'h084, A_VER = 'h0F0;
    localparam int A_CNT  = 'h100;
    localparam int E_RX = 'h40, E_TX = 'h5C, E_CYC = 'h78;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [8:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         cnt_wr = 1'b0;
    logic [63:0]  cnt_wdata = '0;
    logic [63:0]  cnt_rdata;
    logic [255:0] ev = '0;
    logic         irq_o;

    int  n_total = 0;
    int  n_bad   = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    evmon_top i_evmon_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .cnt_rdata (cnt_rdata),
        .ev_i      (ev),
        .irq_o     (irq_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 9'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 9'(a);
        #1 d = reg_rdata;
    endtask

    task automatic cnt_write(input int n, input logic [63:0] d);
        @(negedge clk);
        reg_addr = 9'(A_CNT + 8*n); cnt_wdata = d; cnt_wr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic cnt_read_at(input int a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = 9'(a);
        #1 d = cnt_rdata;
    endtask

    task automatic pulse(input int code, input int n);
        @(negedge clk);
        ev[code] = 1'b1;
        repeat (n) @(negedge clk);
        ev[code] = 1'b0;
    endtask

    task automatic zero_all();
        for (int n = 0; n < 8; n++) cnt_write(n, 64'd0);
    endtask

    task automatic t_reset();
        logic [31:0] r; logic [63:0] c;
        reg_read(A_CTRL, r); chk("R1 ctrl", 64'(r), 64'h0);
        reg_read(A_EVEN, r); chk("R1 enable", 64'(r), 64'h0);
        reg_read(A_MASK, r); chk("R1 mask", 64'(r), 64'hFF);
        reg_read(A_STAT, r); chk("R1 status", 64'(r), 64'h0);
        reg_read(A_SEL1, r); chk("R1 select", 64'(r), 64'h0);
        reg_read(A_VER, r);  chk("R1 version", 64'(r), 64'(VER));
        cnt_read_at(A_CNT + 8*6, c); chk("R1 counter6", c, 64'h0);
        chk("R1 irq", 64'(irq_o), 64'h0);
    endtask

    task automatic t_preload();
        logic [63:0] c;
        for (int n = 0; n < 8; n++) cnt_write(n, 64'hA5A5_0000_1234_0000 + 64'(n * 'h1_0001));
        for (int n = 0; n < 8; n++) begin
            cnt_read_at(A_CNT + 8*n, c);
            chk("R2 preload readback", c, 64'hA5A5_0000_1234_0000 + 64'(n * 'h1_0001));
        end
        zero_all();
    endtask

    task automatic t_enables();
        logic [63:0] c;
        reg_write(A_SEL0, 32'h0040_0000);          // counter 2 -> code 0x40
        reg_write(A_EVEN, 32'h04); reg_write(A_CTRL, 32'h0);
        pulse(E_RX, 5);
        cnt_read_at(A_CNT + 16, c); chk("R3 global off", c, 64'd0);
        reg_write(A_EVEN, 32'h00); reg_write(A_CTRL, 32'h1);
        pulse(E_RX, 5);
        cnt_read_at(A_CNT + 16, c); chk("R3 local off", c, 64'd0);
        reg_write(A_EVEN, 32'h04);
        pulse(E_RX, 5);
        cnt_read_at(A_CNT + 16, c); chk("R3 both on", c, 64'd5);
    endtask

    task automatic t_select();
        logic [63:0] c; logic [31:0] r;
        zero_all();
        reg_write(A_SEL0, 32'h0000_0040);          // counter 0 -> 0x40
        reg_write(A_SEL1, 32'h7800_5C00);          // counter 5 -> 0x5C, counter 7 -> 0x78
        reg_write(A_EVEN, 32'hFF);
        reg_read(A_SEL1, r); chk("R4 select readback", 64'(r), 64'h7800_5C00);
        pulse(E_TX, 3);
        cnt_read_at(A_CNT + 8*5, c); chk("R4 counter5 tx", c, 64'd3);
        cnt_read_at(A_CNT + 8*0, c); chk("R4 counter0 untouched", c, 64'd0);
        cnt_read_at(A_CNT + 8*7, c); chk("R4 counter7 untouched", c, 64'd0);
        pulse(E_CYC, 4);
        cnt_read_at(A_CNT + 8*7, c); chk("R4 counter7 cycles", c, 64'd4);
        pulse(E_RX, 2);
        cnt_read_at(A_CNT + 8*0, c); chk("R4 counter0 rx", c, 64'd2);
        cnt_read_at(A_CNT + 8*5, c); chk("R4 counter5 held", c, 64'd3);
    endtask

    task automatic t_wrap_irq();
        logic [63:0] c; logic [31:0] r;
        reg_write(A_SEL0, 32'h4000_0000);          // counter 3 -> 0x40
        reg_write(A_SEL1, 32'h0);
        cnt_write(3, ~64'd1);
        pulse(E_RX, 2);
        cnt_read_at(A_CNT + 24, c); chk("R5 wrapped to zero", c, 64'd0);
        reg_read(A_STAT, r); chk("R5 status set", 64'(r), 64'h08);
        @(negedge clk); @(negedge clk);
        chk("R7 masked irq low", 64'(irq_o), 64'h0);
        reg_write(A_MASK, 32'hF7);
        @(negedge clk);
        chk("R7 unmasked irq high", 64'(irq_o), 64'h1);
    endtask

    task automatic t_clear();
        logic [31:0] r;
        reg_write(A_CLR, 32'hF7);
        reg_read(A_STAT, r); chk("R6 zero bits keep status", 64'(r), 64'h08);
        reg_write(A_CLR, 32'h08);
        reg_read(A_STAT, r); chk("R6 one bit clears", 64'(r), 64'h0);
        @(negedge clk);
        chk("R7 irq drops after clear", 64'(irq_o), 64'h0);
        // rollover collides with a clear of the same bit
        cnt_write(3, ~64'd0);
        @(negedge clk);
        ev[E_RX] = 1'b1; reg_addr = 9'(A_CLR); reg_wdata = 32'h08; reg_wr = 1'b1;
        @(negedge clk);
        ev[E_RX] = 1'b0; reg_wr = 1'b0;
        reg_read(A_STAT, r); chk("R6 set beats clear", 64'(r), 64'h08);
        reg_write(A_CLR, 32'h08);
        reg_write(A_MASK, 32'hFF);
    endtask

    task automatic t_write_priority();
        logic [63:0] c;
        @(negedge clk);
        ev[E_RX] = 1'b1; reg_addr = 9'(A_CNT + 24); cnt_wdata = 64'd100; cnt_wr = 1'b1;
        @(negedge clk);
        ev[E_RX] = 1'b0; cnt_wr = 1'b0;
        cnt_read_at(A_CNT + 24, c); chk("R8 write beats increment", c, 64'd100);
        pulse(E_RX, 1);
        cnt_read_at(A_CNT + 24, c); chk("R8 counting resumes", c, 64'd101);
    endtask

    task automatic t_unmapped();
        logic [31:0] r; logic [63:0] c;
        reg_read('h040, r);        chk("R9 unmapped 32-bit", 64'(r), 64'h0);
        reg_read(A_CLR, r);        chk("R9 clear reads zero", 64'(r), 64'h0);
        reg_read(A_CNT + 24, r);   chk("R9 counter window on 32-bit", 64'(r), 64'h0);
        cnt_read_at(A_CNT + 28, c); chk("R9 misaligned 64-bit", c, 64'h0);
        cnt_read_at(A_CNT + 64, c); chk("R9 out of range 64-bit", c, 64'h0);
        cnt_read_at(A_CTRL, c);     chk("R9 control on 64-bit", c, 64'h0);
        reg_write(A_VER, 32'h0);
        reg_read(A_VER, r);        chk("R9 version read-only", 64'(r), 64'(VER));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_preload();
        t_enables();
        t_select();
        t_wrap_irq();
        t_clear();
        t_write_priority();
        t_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end
endmodule